// File: doc/BRIEF.md
# HDLC Two-Byte Address Filter

This block sits between an HDLC receive deframer and the receive FIFO. It decides, frame by frame, whether the frame is kept or thrown away. The deframer presents the frame as a byte stream. A start strobe marks the first byte and an end strobe marks the last one. The filter looks only at the first two octets, which carry the address. The upper six bits of octet one are compared against a programmable pattern, and the upper seven bits of octet two are compared against a second pattern. Each comparison has its own enable.

A second octet whose seven upper bits are all ones is a broadcast. A broadcast passes the second comparison whatever pattern is programmed. The filter is never allowed to flip a frame from half-way through. For that reason the register settings and the global enable are captured when a frame starts, and they apply to the whole frame. In the cycle after the end strobe, the block raises exactly one of two one-cycle pulses. The keep pulse tells the FIFO to commit the frame. The drop pulse tells it to flush the frame.

Top module: `hdlc_addr_filter`

## Requirements
- R1: With register 0 bit 0 set, octet one passes only if its bits 7..2 equal register 0 bits 7..2. Register 0 bit 1 takes no part in matching.
- R2: With register 1 bit 0 set, octet two passes only if its bits 7..1 equal register 1 bits 7..1.
- R3: If bits 7..1 of octet two are all ones, the second comparison passes whatever register 1 holds.
- R4: An octet whose enable bit (bit 0 of its register) is clear never causes a drop.
- R5: If `flt_en` is low in the start cycle of a frame, that frame is kept.
- R6: A frame that ends with fewer than two valid bytes is dropped if filtering is on and either enable bit is set. It is kept otherwise.
- R7: A register write applies from the next frame start that comes strictly after the write cycle. A write during a frame, or in the same cycle as a start, leaves the current frame's decision unchanged.
- R8: An end strobe inside a frame is followed, in the next cycle, by exactly one of `keep`/`drop`, high for one cycle. Bytes after the second are ignored. An end strobe outside a frame produces no pulse.
- R9: After reset both outputs are low, and both registers are zero, so every comparison is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_en | input | 1 | Global filter enable, captured at frame start |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects register 0 (octet one), 1 selects register 1 (octet two) |
| wr_data | input | 8 | Register write data |
| rx_sof | input | 1 | First cycle of a frame |
| rx_vld | input | 1 | A byte is present on `rx_byte` |
| rx_byte | input | 8 | Received byte |
| rx_eof | input | 1 | Last cycle of a frame (may carry a byte) |
| keep | output | 1 | One-cycle commit pulse |
| drop | output | 1 | One-cycle flush pulse |

## Verification
The bench programs patterns that differ from the received octet in a single bit. A comparator sliced at the wrong bit position would then keep frames it should drop, or drop frames it should keep. It also sets register 0 bit 1 and bit 0 of each octet, to show that these bits are ignored. A filter that compared them would drop frames that ought to match. Further tests send broadcast octets against a mismatching pattern, frames with zero or one address byte, and register writes in the middle of a frame. A design without the broadcast bypass, with a short-frame rule that keeps frames, or with live register reads would give the wrong pulse. The bench also sends a stray end strobe and checks the pulse width, which would catch duplicated or missing decisions.

// File: rtl/hdlc_addr_filter_pkg.sv
package hdlc_addr_filter_pkg;
  localparam int OCT_W = 8;
  typedef logic [OCT_W-1:0] octet_t;
  typedef logic [1:0] hdr_cnt_t;
endpackage

// File: rtl/haf_regs.sv
module haf_regs
  import hdlc_addr_filter_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   flt_en,
  input  logic   wr_en,
  input  logic   wr_sel,
  input  octet_t wr_data,
  input  logic   rx_sof,
  output octet_t eff0,
  output octet_t eff1,
  output logic   eff_fen
);
  octet_t sh0, sh1, act0, act1;
  logic   act_fen;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh0 <= '0;
      sh1 <= '0;
      act0 <= '0;
      act1 <= '0;
      act_fen <= 1'b0;
    end else begin
      if (wr_en && !wr_sel) sh0 <= wr_data;
      if (wr_en &&  wr_sel) sh1 <= wr_data;
      if (rx_sof) begin
        act0 <= sh0;
        act1 <= sh1;
        act_fen <= flt_en;
      end
    end
  end

  // a starting frame sees the shadow copies as they stood before this edge
  assign eff0    = rx_sof ? sh0 : act0;
  assign eff1    = rx_sof ? sh1 : act1;
  assign eff_fen = rx_sof ? flt_en : act_fen;

  // R7: active settings change only at a frame start
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !rx_sof |=> $stable(act0) && $stable(act1));
endmodule

// File: rtl/haf_cmp.sv
module haf_cmp
  import hdlc_addr_filter_pkg::*;
#(
  parameter int PAT_W = 6,
  parameter bit BCAST = 1'b0
) (
  input  octet_t           data,
  input  logic [PAT_W-1:0] pat,
  input  logic             en,
  output logic             ok
);
  logic [PAT_W-1:0] top_bits;
  logic             hit;
  logic             bc;

  assign top_bits = data[OCT_W-1 -: PAT_W];
  assign hit      = (top_bits == pat);

  generate
    if (BCAST) begin : g_bc
      assign bc = &top_bits;
    end else begin : g_nobc
      assign bc = 1'b0;
    end
  endgenerate

  assign ok = !en || hit || bc;

  always_comb begin
    if (BCAST && (&top_bits)) begin
      p_bcast_r3: assert (ok);
    end
  end
endmodule

// File: rtl/haf_track.sv
module haf_track
  import hdlc_addr_filter_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rx_sof,
  input  logic rx_vld,
  input  logic rx_eof,
  input  logic ok0,
  input  logic ok1,
  input  logic en_any,
  input  logic fen,
  output logic fire,
  output logic keep,
  output logic drop
);
  logic     in_frame;
  hdr_cnt_t cnt, cnt_e, cnt_n;
  logic     ok0_q, ok0_e, ok0_n;
  logic     pass_q, pass_e, pass_n;
  logic     act;

  assign act    = rx_sof || in_frame;
  assign cnt_e  = rx_sof ? 2'd0 : cnt;
  assign ok0_e  = rx_sof ? 1'b0 : ok0_q;
  assign pass_e = rx_sof ? 1'b0 : pass_q;
  assign fire   = act && rx_eof;

  always_comb begin
    cnt_n  = cnt_e;
    ok0_n  = ok0_e;
    pass_n = pass_e;
    if (act && rx_vld) begin
      if (cnt_e == 2'd0) ok0_n = ok0;
      if (cnt_e == 2'd1) pass_n = ok0_e && ok1;
      if (cnt_e != 2'd2) cnt_n = cnt_e + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame <= 1'b0;
      cnt <= '0;
      ok0_q <= 1'b0;
      pass_q <= 1'b0;
      keep <= 1'b0;
      drop <= 1'b0;
    end else begin
      keep <= 1'b0;
      drop <= 1'b0;
      if (act) begin
        cnt <= cnt_n;
        ok0_q <= ok0_n;
        pass_q <= pass_n;
      end
      in_frame <= act && !rx_eof;
      if (fire) begin
        if (!fen)               keep <= 1'b1;
        else if (cnt_n != 2'd2) begin
          keep <= !en_any;
          drop <= en_any;
        end else begin
          keep <= pass_n;
          drop <= !pass_n;
        end
      end
    end
  end

  p_cnt_sat_r8: assert property (@(posedge clk) disable iff (rst)
    cnt != 2'd3);
  p_excl_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({keep, drop}));
endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter
  import hdlc_addr_filter_pkg::*;
#(
  parameter int P0_W = 6,
  parameter int P1_W = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       flt_en,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       rx_sof,
  input  logic       rx_vld,
  input  logic [7:0] rx_byte,
  input  logic       rx_eof,
  output logic       keep,
  output logic       drop
);
  octet_t eff0, eff1;
  logic   eff_fen, ok0, ok1, fire;

  haf_regs u_regs (
    .clk(clk), .rst(rst), .flt_en(flt_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rx_sof(rx_sof), .eff0(eff0), .eff1(eff1),
    .eff_fen(eff_fen)
  );

  haf_cmp #(.PAT_W(P0_W), .BCAST(1'b0)) u_cmp0 (
    .data(rx_byte), .pat(eff0[OCT_W-1 -: P0_W]), .en(eff0[0]), .ok(ok0)
  );

  haf_cmp #(.PAT_W(P1_W), .BCAST(1'b1)) u_cmp1 (
    .data(rx_byte), .pat(eff1[OCT_W-1 -: P1_W]), .en(eff1[0]), .ok(ok1)
  );

  haf_track u_track (
    .clk(clk), .rst(rst), .rx_sof(rx_sof), .rx_vld(rx_vld), .rx_eof(rx_eof),
    .ok0(ok0), .ok1(ok1), .en_any(eff0[0] || eff1[0]), .fen(eff_fen),
    .fire(fire), .keep(keep), .drop(drop)
  );

  // R8: every frame end yields a decision in the next cycle
  p_decide_r8: assert property (@(posedge clk) disable iff (rst)
    fire |=> (keep || drop));
  p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !fire |=> !(keep || drop));
  // R9: nothing is decided straight out of reset
  p_rst_r9: assert property (@(posedge clk)
    rst |=> !(keep || drop));
endmodule

// File: tb/hdlc_addr_filter_tb_top.sv
module hdlc_addr_filter_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flt_en = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
  logic [7:0] wr_data = '0, rx_byte = '0;
  logic rx_sof = 1'b0, rx_vld = 1'b0, rx_eof = 1'b0;
  logic keep, drop;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hdlc_addr_filter dut_i (
    .clk(clk), .rst(rst), .flt_en(flt_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rx_sof(rx_sof), .rx_vld(rx_vld), .rx_byte(rx_byte),
    .rx_eof(rx_eof), .keep(keep), .drop(drop)
  );

  task automatic chk(input string req, input logic [1:0] got, input logic [1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: {keep,drop} actual %b expected %b", req, got, exp);
    end
  endtask

  task automatic wreg(input logic sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // frame of n bytes; checks the decision pulse and that it lasts one cycle
  task automatic frame(input string req, input int n, input logic [7:0] b0,
                       input logic [7:0] b1, input logic [1:0] exp);
    int cyc;
    cyc = (n == 0) ? 1 : n;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      rx_sof = (i == 0);
      rx_eof = (i == cyc - 1);
      rx_vld = (n != 0);
      rx_byte = (i == 0) ? b0 : (i == 1) ? b1 : 8'h5A;
    end
    @(negedge clk);
    rx_sof = 0; rx_eof = 0; rx_vld = 0;
    chk(req, {keep, drop}, exp);
    @(negedge clk);
    chk({req, " pulse width"}, {keep, drop}, 2'b00);
  endtask

  task automatic t_reset();
    chk("R9 reset", {keep, drop}, 2'b00);
    flt_en = 1'b1;
    frame("R9 regs zero", 2, 8'h00, 8'h00, 2'b10);
  endtask

  task automatic t_oct1();
    wreg(0, 8'hA9);
    frame("R1 match", 2, 8'hAB, 8'h00, 2'b10);
    frame("R1 mismatch bit2", 2, 8'hAE, 8'h00, 2'b01);
    wreg(0, 8'hAB);
    frame("R1 bit1 ignored", 2, 8'hA8, 8'h00, 2'b10);
    wreg(0, 8'h00);
  endtask

  task automatic t_oct2();
    wreg(1, 8'h35);
    frame("R2 match", 2, 8'h00, 8'h34, 2'b10);
    frame("R2 bit0 ignored", 2, 8'h00, 8'h35, 2'b10);
    frame("R2 mismatch bit1", 2, 8'h00, 8'h36, 2'b01);
    frame("R3 broadcast FE", 2, 8'h00, 8'hFE, 2'b10);
    frame("R3 broadcast FF", 2, 8'h00, 8'hFF, 2'b10);
    wreg(0, 8'h01);
    frame("R3 bcast with oct1 miss", 2, 8'hFC, 8'hFF, 2'b01);
    wreg(0, 8'h00);
    wreg(1, 8'h34);
    frame("R4 oct2 disabled", 2, 8'hFF, 8'h00, 2'b10);
  endtask

  task automatic t_global();
    wreg(1, 8'h35);
    flt_en = 1'b0;
    frame("R5 filter off", 2, 8'h00, 8'h00, 2'b10);
    flt_en = 1'b1;
    frame("R5 filter on", 2, 8'h00, 8'h00, 2'b01);
  endtask

  task automatic t_short();
    frame("R6 one byte enabled", 1, 8'h34, 8'h00, 2'b01);
    frame("R6 zero bytes enabled", 0, 8'h00, 8'h00, 2'b01);
    wreg(1, 8'h00);
    frame("R6 one byte none enabled", 1, 8'h34, 8'h00, 2'b10);
  endtask

  task automatic t_latch();
    wreg(0, 8'hA9);
    @(negedge clk);
    rx_sof = 1; rx_vld = 1; rx_byte = 8'hA8;
    wr_en = 1; wr_sel = 0; wr_data = 8'h01;
    @(negedge clk);
    rx_sof = 0; rx_byte = 8'h00; wr_en = 1; wr_data = 8'h05;
    @(negedge clk);
    wr_en = 0; rx_eof = 1; rx_byte = 8'h77;
    @(negedge clk);
    rx_eof = 0; rx_vld = 0;
    chk("R7 mid-frame write ignored", {keep, drop}, 2'b10);
    frame("R7 new value next frame", 2, 8'hA8, 8'h00, 2'b01);
    wreg(0, 8'h00);
  endtask

  task automatic t_tail();
    wreg(1, 8'h35);
    frame("R8 long frame tail ignored", 4, 8'h00, 8'h34, 2'b10);
    @(negedge clk);
    rx_eof = 1;
    @(negedge clk);
    rx_eof = 0;
    chk("R8 stray eof", {keep, drop}, 2'b00);
    @(negedge clk);
    chk("R8 stray eof late", {keep, drop}, 2'b00);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_oct1();
    t_oct2();
    t_global();
    t_short();
    t_latch();
    t_tail();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end
endmodule